// File: doc/BRIEF.md
# Row Write Collector with Self-Timed Commit

This block sits between a serial-bus protocol engine and a 128-byte storage array. While a write command is open it gathers incoming data bytes into a four-entry row buffer. The row is fixed by the upper five address bits given with the command. A two-bit column pointer picks the entry for each byte, starting from the low two address bits. Every entry that receives a byte is flagged in a per-entry mask.

When the bus transaction ends with STOP, the block enters a busy period of fixed length. The length is set by a parameter and counted in ticks of a slow timebase. At the end of that period it replays the flagged entries into the array through a write strobe, one entry slot per clock, and then drops busy. While busy, it ignores every command input.

A write that arrived with the write-control input high is refused, and so is a command with no data bytes. Neither starts a busy period or touches the array. A new START always discards whatever the buffer held.

Top module: `page_commit_engine`

## Requirements
- R1: After reset, `busy_o` and `arr_we_o` are low.
- R2: Each accepted byte is stored at the current column, and the column then advances by one modulo 4. A later byte landing on an already loaded column replaces the earlier value.
- R3: Every array write issued for a command uses that command's address bits [6:2] as `arr_addr_o[6:2]`. Bits [1:0] give the entry slot.
- R4: The commit walks slots 0, 1, 2, 3 on four consecutive clocks. `arr_we_o` is high only on the slots that received a byte since the last START.
- R5: A STOP accepted with at least one stored byte raises `busy_o` on the next clock. The block then waits PROG_TICKS `tick_i` pulses, runs the four commit clocks, and lowers `busy_o` after the last one.
- R6: A command given with `wc_i` high accepts no bytes. Its STOP starts no busy period and causes no array write.
- R7: A STOP after a command with no data bytes leaves `busy_o` low and writes nothing.
- R8: While `busy_o` is high, `start_i`, `cmd_i`, `byte_vld_i` and `stop_i` have no effect. The address and data committed are those of the command that started the busy period.
- R9: A START clears every entry flag and closes any open command. Bytes received before it are never written.
- R10: `arr_we_o` is never high while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase pulse that advances the program timer |
| start_i | input | 1 | START seen on the bus (one-clock pulse) |
| cmd_i | input | 1 | Write command decoded (one-clock pulse) |
| cmd_addr_i | input | 7 | Byte address given with the command |
| wc_i | input | 1 | Write-control level sampled with the command; 1 = protected |
| byte_vld_i | input | 1 | Data byte received (one-clock pulse) |
| byte_i | input | 8 | Data byte value |
| stop_i | input | 1 | STOP seen on the bus (one-clock pulse) |
| busy_o | output | 1 | Program cycle in progress |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | 7 | Array write address |
| arr_wdata_o | output | 8 | Array write data |

## Verification
The hardest case to reach from the ports is stimulus that arrives while the program cycle is running. This matters most on the clocks where the timer expires and where the commit hands back to idle, because a stray STOP or byte there could restart or corrupt the commit. The stimulus sends a full new command, bytes and STOP during a busy period. The tick runs at a rate unrelated to those pulses, so over the run they land on different phases of the wait and commit. Wrapping writes of six bytes and writes starting mid-row cover the column pointer's overwrite and out-of-order slot cases.

// File: rtl/pcl_pkg.sv
package pcl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_WAIT   = 2'd1,
    PH_COMMIT = 2'd2
  } phase_t;
endpackage

// File: rtl/pcl_row_latch.sv
module pcl_row_latch #(
  parameter int SLOTS  = 4,
  parameter int DATA_W = 8,
  localparam int COL_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              seek_i,
  input  logic [COL_W-1:0]  seek_col_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [COL_W-1:0]  rd_sel_i,
  output logic [SLOTS-1:0]  mask_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [COL_W-1:0]  col_q, col_d;
  logic [DATA_W-1:0] ent_q [SLOTS];

  // column pointer: loaded by a command, stepped after each stored byte
  always_comb begin
    col_d = col_q;
    if (seek_i)    col_d = seek_col_i;
    else if (wr_i) col_d = col_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_q <= '0;
    else        col_q <= col_d;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_ent
    logic hit;
    logic flag_d;
    assign hit = wr_i && (col_q == COL_W'(g));

    always_comb begin
      flag_d = mask_o[g];
      if (clr_i)    flag_d = 1'b0;
      else if (hit) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_o[g] <= 1'b0;
      else        mask_o[g] <= flag_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ent_q[g] <= '0;
      else if (hit) ent_q[g] <= data_i;
    end
  end

  assign rd_data_o = ent_q[rd_sel_i];
endmodule

// File: rtl/pcl_prog_timer.sv
module pcl_prog_timer #(
  parameter int PROG_TICKS = 10000,
  localparam int CNT_W = $clog2(PROG_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  assign last     = (cnt_q == CNT_W'(PROG_TICKS - 1));
  assign expire_o = run_i && tick_i && last;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)      cnt_d = '0;
    else if (tick_i) cnt_d = last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pcl_seq.sv
module pcl_seq
  import pcl_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int ADDR_W = 7,
  localparam int COL_W = $clog2(SLOTS),
  localparam int ROW_W = ADDR_W - COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cmd_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              wc_i,
  input  logic              byte_vld_i,
  input  logic              stop_i,
  input  logic [SLOTS-1:0]  mask_i,
  input  logic              expire_i,
  output logic              run_o,
  output logic              clr_o,
  output logic              seek_o,
  output logic [COL_W-1:0]  seek_col_o,
  output logic              wr_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  slot_o,
  output logic              busy_o,
  output logic              we_o
);
  phase_t           ph_q, ph_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] slot_q, slot_d;
  logic             armed_q, armed_d;
  logic             block_q, block_d;
  logic             open_ok;
  logic             last_slot;

  assign open_ok   = armed_q && !block_q;
  assign last_slot = (slot_q == COL_W'(SLOTS - 1));

  always_comb begin
    ph_d    = ph_q;
    row_d   = row_q;
    slot_d  = slot_q;
    armed_d = armed_q;
    block_d = block_q;
    clr_o   = 1'b0;
    seek_o  = 1'b0;
    wr_o    = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          clr_o   = 1'b1;
          armed_d = 1'b0;
        end else if (cmd_i) begin
          seek_o  = 1'b1;
          row_d   = cmd_addr_i[ADDR_W-1:COL_W];
          block_d = wc_i;
          armed_d = 1'b1;
        end else if (byte_vld_i) begin
          wr_o = open_ok;
        end else if (stop_i) begin
          armed_d = 1'b0;
          if (open_ok && (|mask_i)) ph_d = PH_WAIT;
        end
      end
      PH_WAIT: begin
        if (expire_i) begin
          ph_d   = PH_COMMIT;
          slot_d = '0;
        end
      end
      PH_COMMIT: begin
        if (last_slot) begin
          ph_d  = PH_IDLE;
          clr_o = 1'b1;
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      row_q   <= '0;
      slot_q  <= '0;
      armed_q <= 1'b0;
      block_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      row_q   <= row_d;
      slot_q  <= slot_d;
      armed_q <= armed_d;
      block_q <= block_d;
    end
  end

  assign seek_col_o = cmd_addr_i[COL_W-1:0];
  assign run_o      = (ph_q == PH_WAIT);
  assign busy_o     = (ph_q != PH_IDLE);
  assign we_o       = (ph_q == PH_COMMIT) && mask_i[slot_q];
  assign row_o      = row_q;
  assign slot_o     = slot_q;
endmodule

// File: rtl/page_commit_engine.sv
module page_commit_engine #(
  parameter int SLOTS      = 4,
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 8,
  parameter int PROG_TICKS = 10000,
  localparam int COL_W     = $clog2(SLOTS),
  localparam int ROW_W     = ADDR_W - COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              cmd_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              wc_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              stop_i,
  output logic              busy_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_wdata_o
);
  logic [SLOTS-1:0] mask;
  logic             expire, run, clr, seek, wr;
  logic [COL_W-1:0] seek_col, slot;
  logic [ROW_W-1:0] row;

  pcl_seq #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .cmd_i      (cmd_i),
    .cmd_addr_i (cmd_addr_i),
    .wc_i       (wc_i),
    .byte_vld_i (byte_vld_i),
    .stop_i     (stop_i),
    .mask_i     (mask),
    .expire_i   (expire),
    .run_o      (run),
    .clr_o      (clr),
    .seek_o     (seek),
    .seek_col_o (seek_col),
    .wr_o       (wr),
    .row_o      (row),
    .slot_o     (slot),
    .busy_o     (busy_o),
    .we_o       (arr_we_o)
  );

  pcl_row_latch #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr),
    .seek_i     (seek),
    .seek_col_i (seek_col),
    .wr_i       (wr),
    .data_i     (byte_i),
    .rd_sel_i   (slot),
    .mask_o     (mask),
    .rd_data_o  (arr_wdata_o)
  );

  pcl_prog_timer #(.PROG_TICKS(PROG_TICKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run),
    .tick_i   (tick_i),
    .expire_o (expire)
  );

  assign arr_addr_o = {row, slot};
endmodule

// File: rtl/pcl_checker.sv
module pcl_checker #(
  parameter int ADDR_W = 7,
  parameter int COL_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_i,
  input logic              busy_o,
  input logic              arr_we_o,
  input logic [ADDR_W-1:0] arr_addr_o
);
  assert_we_inside_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> busy_o);

  assert_busy_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i));

  assert_row_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(arr_addr_o[ADDR_W-1:COL_W]));

  assert_slot_ascends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we_o && $past(arr_we_o)) |->
      (arr_addr_o[COL_W-1:0] == COL_W'($past(arr_addr_o[COL_W-1:0]) + 1'b1)));

  assert_row_matches_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we_o && $past(busy_o)) |-> $stable(arr_addr_o[ADDR_W-1:COL_W]));
endmodule

bind page_commit_engine pcl_checker #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stop_i     (stop_i),
  .busy_o     (busy_o),
  .arr_we_o   (arr_we_o),
  .arr_addr_o (arr_addr_o)
);

// File: tb/test_page_commit_engine.sv
module test_page_commit_engine;
  localparam int PT = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       start_i = 1'b0, cmd_i = 1'b0, wc_i = 1'b0, byte_vld_i = 1'b0, stop_i = 1'b0;
  logic [6:0] cmd_addr_i = '0;
  logic [7:0] byte_i = '0;
  logic       busy_o, arr_we_o;
  logic [6:0] arr_addr_o;
  logic [7:0] arr_wdata_o;

  int total = 0, bad = 0;
  bit finished = 0;
  string cur_req = "R1";
  logic [14:0] obs [$];
  logic [14:0] exp_q [$];

  always #2 clk = ~clk;

  page_commit_engine #(.PROG_TICKS(PT)) i_page_commit_engine (.*);

  // timebase: one tick every third clock
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 3;
    tick_i <= (tdiv == 0);
  end

  // behavioural reference
  int  m_ph = 0, m_cnt = 0, m_slot = 0, m_col = 0, m_row = 0;
  bit  m_armed = 0, m_block = 0;
  bit  m_flag [4];
  int  m_val [4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_armed = 0; m_block = 0; m_col = 0;
      for (int i = 0; i < 4; i++) m_flag[i] = 0;
    end else if (m_ph == 0) begin
      if (start_i) begin
        m_armed = 0;
        for (int i = 0; i < 4; i++) m_flag[i] = 0;
      end else if (cmd_i) begin
        m_row = cmd_addr_i / 4; m_col = cmd_addr_i % 4;
        m_block = wc_i; m_armed = 1;
      end else if (byte_vld_i) begin
        if (m_armed && !m_block) begin
          m_val[m_col] = byte_i; m_flag[m_col] = 1; m_col = (m_col + 1) % 4;
        end
      end else if (stop_i) begin
        if (m_armed && !m_block && (m_flag[0] || m_flag[1] || m_flag[2] || m_flag[3])) begin
          m_ph = 1; m_cnt = 0;
        end
        m_armed = 0;
      end
    end else if (m_ph == 1) begin
      if (tick_i) begin
        if (m_cnt == PT - 1) begin m_ph = 2; m_slot = 0; end
        else m_cnt++;
      end
    end else begin
      if (m_slot == 3) begin
        m_ph = 0;
        for (int i = 0; i < 4; i++) m_flag[i] = 0;
      end else m_slot++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit ebusy, ewe;
      ebusy = (m_ph != 0);
      ewe   = (m_ph == 2) && m_flag[m_slot];
      total++;
      if (busy_o !== ebusy || arr_we_o !== ewe ||
          (ewe && (arr_addr_o !== 7'(m_row * 4 + m_slot) || arr_wdata_o !== 8'(m_val[m_slot])))) begin
        bad++;
        $display("FAIL %s model: busy=%b we=%b addr=%h data=%h exp busy=%b we=%b addr=%h data=%h",
                 cur_req, busy_o, arr_we_o, arr_addr_o, arr_wdata_o, ebusy, ewe,
                 7'(m_row * 4 + m_slot), 8'(m_val[m_slot]));
      end
      if (arr_we_o) obs.push_back({arr_addr_o, arr_wdata_o});
    end
  end

  task automatic pulse_start();
    @(negedge clk); start_i = 1; @(negedge clk); start_i = 0;
  endtask
  task automatic pulse_cmd(input logic [6:0] a, input logic wc);
    @(negedge clk); cmd_i = 1; cmd_addr_i = a; wc_i = wc; @(negedge clk); cmd_i = 0;
  endtask
  task automatic pulse_byte(input logic [7:0] d);
    @(negedge clk); byte_vld_i = 1; byte_i = d; @(negedge clk); byte_vld_i = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); stop_i = 1; @(negedge clk); stop_i = 0;
  endtask
  task automatic settle();
    repeat (3) @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask
  task automatic check_writes(input string req);
    total++;
    if (obs.size() != exp_q.size()) begin
      bad++;
      $display("FAIL %s write count: got %0d expected %0d", req, obs.size(), exp_q.size());
    end else begin
      foreach (exp_q[i]) if (obs[i] !== exp_q[i]) begin
        bad++;
        $display("FAIL %s write %0d: got %h expected %h", req, i, obs[i], exp_q[i]);
        break;
      end
    end
    obs.delete(); exp_q.delete();
  endtask
  task automatic check_bit(input string req, input logic got, input logic expv);
    total++;
    if (got !== expv) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, got, expv);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check_bit("R1 busy", busy_o, 1'b0);
    check_bit("R1 we", arr_we_o, 1'b0);
    rst_n = 1;
    @(negedge clk);

    // R5 single byte: busy rises the clock after STOP
    cur_req = "R5";
    pulse_start(); pulse_cmd(7'h25, 0); pulse_byte(8'hA5);
    @(negedge clk); stop_i = 1; @(negedge clk); stop_i = 0;
    check_bit("R5 busy after stop", busy_o, 1'b1);
    settle();
    exp_q.push_back({7'h25, 8'hA5});
    check_writes("R5");

    // R3 R4: start mid-row, three bytes -> slots 2,3,0
    cur_req = "R4";
    pulse_start(); pulse_cmd(7'h4E, 0);
    pulse_byte(8'h11); pulse_byte(8'h22); pulse_byte(8'h33);
    pulse_stop(); settle();
    exp_q.push_back({7'h4C, 8'h33});
    exp_q.push_back({7'h4E, 8'h11});
    exp_q.push_back({7'h4F, 8'h22});
    check_writes("R3 R4");

    // R2: six bytes wrap and overwrite
    cur_req = "R2";
    pulse_start(); pulse_cmd(7'h10, 0);
    for (int i = 1; i <= 6; i++) pulse_byte(8'(i * 16 + i));
    pulse_stop(); settle();
    exp_q.push_back({7'h10, 8'h55});
    exp_q.push_back({7'h11, 8'h66});
    exp_q.push_back({7'h12, 8'h33});
    exp_q.push_back({7'h13, 8'h44});
    check_writes("R2");

    // R6: protected command
    cur_req = "R6";
    pulse_start(); pulse_cmd(7'h08, 1); pulse_byte(8'hEE); pulse_byte(8'hDD);
    @(negedge clk); stop_i = 1; @(negedge clk); stop_i = 0;
    check_bit("R6 no busy", busy_o, 1'b0);
    settle();
    check_writes("R6");

    // R7: STOP with no data
    cur_req = "R7";
    pulse_start(); pulse_cmd(7'h60, 0);
    @(negedge clk); stop_i = 1; @(negedge clk); stop_i = 0;
    check_bit("R7 no busy", busy_o, 1'b0);
    settle();
    check_writes("R7");

    // R9: START discards earlier bytes
    cur_req = "R9";
    pulse_start(); pulse_cmd(7'h30, 0); pulse_byte(8'h01); pulse_byte(8'h02);
    pulse_start(); pulse_cmd(7'h33, 0); pulse_byte(8'h77);
    pulse_stop(); settle();
    exp_q.push_back({7'h33, 8'h77});
    check_writes("R9");

    // R8: traffic during busy is ignored; R10 covered by model each clock
    for (int k = 0; k < 4; k++) begin
      cur_req = "R8";
      pulse_start(); pulse_cmd(7'h70, 0); pulse_byte(8'hC0); pulse_byte(8'hC1);
      pulse_stop();
      repeat (k) @(negedge clk);
      pulse_start(); pulse_cmd(7'h01, 0); pulse_byte(8'h99); pulse_stop();
      pulse_byte(8'h98); pulse_stop(); pulse_stop();
      settle();
      exp_q.push_back({7'h70, 8'hC0});
      exp_q.push_back({7'h71, 8'hC1});
      check_writes("R8 R10");
    end
    check_bit("R10 idle we", arr_we_o, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule